// File: doc/BRIEF.md
# Programmable Sample Sequence Stepper

This block drives the front end of a converter through a short program of sample steps. Each trigger starts the program at step 0. For every step the block presents a channel select, a differential-mode flag and a temperature-sensor select, and pulses a conversion request. It then waits for the converter's done pulse and pushes the returned result, tagged with its step index, toward a result FIFO. A step may also raise an interrupt when its result is pushed.

Two 16-bit configuration words hold the program. The select word holds one channel field per step. The control word holds one 4-bit attribute group per step. The sequence length comes from an end marker, which may sit on any step. Both words are copied into a shadow when a sequence starts, so software may rewrite them while a sequence runs. A trigger that arrives during a run is held and starts a fresh sequence as soon as the current one finishes.

Top module: `seq_stepper`

## Requirements
- R1: After reset both configuration words read 0, `busy` is 0, and `conv_req`, `res_push`, `irq` and `cfg_err` are all 0.
- R2: In the select word, the channel of step s sits in bits [4s+1:4s], which are bits 1:0, 5:4, 9:8 and 13:12 for steps 0 to 3. All other bits are discarded on write and read back as 0.
- R3: In the control word, step s owns bits [4s+3:4s]. Within a group, bit 0 is differential, bit 1 is end-of-sequence, bit 2 is interrupt enable and bit 3 is temperature-sensor select. All 16 bits read back as written.
- R4: While `conv_req` is high, `conv_chan`, `conv_diff` and `conv_temp` carry the current step's fields. `conv_req` lasts exactly one cycle. The three selects stay unchanged until the done pulse is accepted.
- R5: A `conv_done` pulse that arrives while the block waits for a result causes `res_push` in the next cycle. That push carries the sampled `conv_data` and the step index on `res_step`. Steps run in ascending order from 0.
- R6: The sequence ends after the first step whose end bit is set, and `busy` is 0 in the cycle after that step's push.
- R7: If no step has its end bit set, all four steps run, and `cfg_err` is high in the same cycle as the push of step 3. At all other times it is 0.
- R8: `irq` is high for exactly the push cycle of each step whose interrupt-enable bit is set, and is otherwise 0.
- R9: A trigger that arrives while a sequence runs is held. `conv_req` for step 0 of the new sequence follows in the cycle right after the final push.
- R10: Writes to the configuration words during a sequence do not change that sequence. They take effect at the next sequence start.
- R11: A `conv_done` pulse is ignored while the block is idle or in its request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_wr_en | input | 1 | Write strobe for the select word |
| mux_wr_data | input | 16 | Select word write data |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wr_data | input | 16 | Control word write data |
| mux_rd_data | output | 16 | Select word readback |
| ctl_rd_data | output | 16 | Control word readback |
| trig | input | 1 | Sequence start request |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 2 | Channel select for the current step |
| conv_diff | output | 1 | Differential-mode select for the current step |
| conv_temp | output | 1 | Temperature-sensor select for the current step |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 10 | Conversion result, valid with `conv_done` |
| res_push | output | 1 | Result push strobe |
| res_data | output | 10 | Result being pushed |
| res_step | output | 2 | Step index of the pushed result |
| irq | output | 1 | Interrupt pulse for the pushed step |
| cfg_err | output | 1 | Program had no end marker; flagged on the fourth push |
| busy | output | 1 | A sequence is in progress |

## Verification
A wrong step counter appears within a single push, because `res_step` or the channel seen at the next request no longer matches the step the program expects. A corrupt shadow or a decode error shows up at the very next request as the wrong channel or attribute flags, or as a sequence that ends early or late. A lost held trigger shows up one cycle after the final push as a missing request. The bench compares every request and every push against a model of the program and checks `busy` one cycle after the expected last step.

// File: rtl/seq_stepper_pkg.sv
package seq_stepper_pkg;

   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_REQUEST   = 2'd1,
      ST_WAIT_DONE = 2'd2,
      ST_PUSH      = 2'd3
   } stp_state_e;

   localparam int unsigned GRP_W      = 4;
   localparam int unsigned CTL_DIFF_B = 0;
   localparam int unsigned CTL_END_B  = 1;
   localparam int unsigned CTL_IE_B   = 2;
   localparam int unsigned CTL_TEMP_B = 3;

   typedef struct packed {
      logic temp;
      logic ie;
      logic last;
      logic diff;
   } step_attr_t;

   function automatic logic [31:0] chan_mask(input int unsigned steps,
                                             input int unsigned ch_w);
      logic [31:0] m;
      m = '0;
      for (int s = 0; s < int'(steps); s++) begin
         for (int b = 0; b < int'(ch_w); b++) begin
            m[s*GRP_W + b] = 1'b1;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs
   import seq_stepper_pkg::*;
#(
   parameter int unsigned REG_W     = 16,
   parameter int unsigned NUM_STEPS = 4,
   parameter int unsigned CH_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mux_wr_en,
   input  logic [REG_W-1:0] mux_wr_data,
   input  logic             ctl_wr_en,
   input  logic [REG_W-1:0] ctl_wr_data,
   output logic [REG_W-1:0] mux_q,
   output logic [REG_W-1:0] ctl_q
);

   localparam logic [31:0]      MASK32   = chan_mask(NUM_STEPS, CH_W);
   localparam logic [REG_W-1:0] MUX_MASK = MASK32[REG_W-1:0];
   localparam int unsigned      CTL_BITS = NUM_STEPS * GRP_W;

   logic [REG_W-1:0] ctl_mask;

   generate
      if (CTL_BITS >= REG_W) begin : g_ctl_full
         assign ctl_mask = '1;
      end else begin : g_ctl_part
         assign ctl_mask = {{(REG_W-CTL_BITS){1'b0}}, {CTL_BITS{1'b1}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mux_q <= '0;
      end else if (mux_wr_en) begin
         mux_q <= mux_wr_data & MUX_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr_en) begin
         ctl_q <= ctl_wr_data & ctl_mask;
      end
   end

endmodule

// File: rtl/seq_step_sel.sv
module seq_step_sel
   import seq_stepper_pkg::*;
#(
   parameter int unsigned REG_W     = 16,
   parameter int unsigned NUM_STEPS = 4,
   parameter int unsigned CH_W      = 2,
   parameter bit          SNAPSHOT  = 1'b1,
   localparam int unsigned STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [REG_W-1:0]  mux_live,
   input  logic [REG_W-1:0]  ctl_live,
   input  logic [STEP_W-1:0] step,
   output logic [CH_W-1:0]   chan,
   output step_attr_t        attr,
   output logic              no_end
);

   logic [REG_W-1:0] mux_src;
   logic [REG_W-1:0] ctl_src;

   generate
      if (SNAPSHOT) begin : g_shadow
         logic [REG_W-1:0] mux_sh;
         logic [REG_W-1:0] ctl_sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mux_sh <= '0;
               ctl_sh <= '0;
            end else if (load) begin
               mux_sh <= mux_live;
               ctl_sh <= ctl_live;
            end
         end
         assign mux_src = mux_sh;
         assign ctl_src = ctl_sh;
      end else begin : g_live
         logic unused_load;
         assign unused_load = load;
         assign mux_src = mux_live;
         assign ctl_src = ctl_live;
      end
   endgenerate

   logic [CH_W-1:0]      chan_arr [NUM_STEPS];
   step_attr_t           attr_arr [NUM_STEPS];
   logic [NUM_STEPS-1:0] end_vec;

   for (genvar s = 0; s < int'(NUM_STEPS); s++) begin : g_step
      assign chan_arr[s]      = mux_src[s*GRP_W +: CH_W];
      assign attr_arr[s].diff = ctl_src[s*GRP_W + CTL_DIFF_B];
      assign attr_arr[s].ie   = ctl_src[s*GRP_W + CTL_IE_B];
      assign attr_arr[s].temp = ctl_src[s*GRP_W + CTL_TEMP_B];
      if (s == int'(NUM_STEPS) - 1) begin : g_tail
         assign attr_arr[s].last = 1'b1;
      end else begin : g_mid
         assign attr_arr[s].last = ctl_src[s*GRP_W + CTL_END_B];
      end
      assign end_vec[s] = ctl_src[s*GRP_W + CTL_END_B];
   end

   always_comb begin
      chan = chan_arr[step];
      attr = attr_arr[step];
   end

   assign no_end = ~|end_vec;

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import seq_stepper_pkg::*;
#(
   parameter int unsigned NUM_STEPS = 4,
   parameter int unsigned RES_W     = 10,
   localparam int unsigned STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   input  step_attr_t        attr,
   input  logic              no_end,
   output logic              load,
   output logic [STEP_W-1:0] step,
   output stp_state_e        state,
   output logic              conv_req,
   output logic              res_push,
   output logic [RES_W-1:0]  res_data,
   output logic              irq,
   output logic              cfg_err,
   output logic              busy
);

   localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(NUM_STEPS - 1);

   stp_state_e        state_q, state_d;
   logic [STEP_W-1:0] step_q, step_d;
   logic              pend_q;
   logic [RES_W-1:0]  data_q;
   logic              go;

   assign go = trig | pend_q;

   always_comb begin
      state_d = state_q;
      step_d  = step_q;
      load    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (go) begin
               state_d = ST_REQUEST;
               step_d  = '0;
               load    = 1'b1;
            end
         end
         ST_REQUEST: begin
            state_d = ST_WAIT_DONE;
         end
         ST_WAIT_DONE: begin
            if (conv_done) begin
               state_d = ST_PUSH;
            end
         end
         ST_PUSH: begin
            if (attr.last) begin
               if (go) begin
                  state_d = ST_REQUEST;
                  step_d  = '0;
                  load    = 1'b1;
               end else begin
                  state_d = ST_IDLE;
               end
            end else begin
               state_d = ST_REQUEST;
               step_d  = step_q + STEP_W'(1);
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
         pend_q  <= load ? 1'b0 : (pend_q | trig);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (state_q == ST_WAIT_DONE && conv_done) begin
         data_q <= conv_data;
      end
   end

   assign step     = step_q;
   assign state    = state_q;
   assign conv_req = (state_q == ST_REQUEST);
   assign res_push = (state_q == ST_PUSH);
   assign res_data = data_q;
   assign irq      = res_push & attr.ie;
   assign cfg_err  = res_push & no_end & (step_q == LAST_IDX);
   assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/seq_stepper.sv
module seq_stepper
   import seq_stepper_pkg::*;
#(
   parameter int unsigned REG_W     = 16,
   parameter int unsigned NUM_STEPS = 4,
   parameter int unsigned CH_W      = 2,
   parameter int unsigned RES_W     = 10,
   parameter bit          SNAPSHOT  = 1'b1,
   localparam int unsigned STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mux_wr_en,
   input  logic [REG_W-1:0]  mux_wr_data,
   input  logic              ctl_wr_en,
   input  logic [REG_W-1:0]  ctl_wr_data,
   output logic [REG_W-1:0]  mux_rd_data,
   output logic [REG_W-1:0]  ctl_rd_data,
   input  logic              trig,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_chan,
   output logic              conv_diff,
   output logic              conv_temp,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   output logic              res_push,
   output logic [RES_W-1:0]  res_data,
   output logic [STEP_W-1:0] res_step,
   output logic              irq,
   output logic              cfg_err,
   output logic              busy
);

   generate
      if (NUM_STEPS < 1 || NUM_STEPS * GRP_W > REG_W) begin : g_bad_steps
         $error("seq_stepper: NUM_STEPS groups do not fit in REG_W");
      end
      if (CH_W < 1 || CH_W > GRP_W) begin : g_bad_chw
         $error("seq_stepper: CH_W must lie in 1..4");
      end
      if (RES_W < 1) begin : g_bad_resw
         $error("seq_stepper: RES_W must be positive");
      end
      if (REG_W > 32) begin : g_bad_regw
         $error("seq_stepper: REG_W above 32 unsupported");
      end
   endgenerate

   logic [REG_W-1:0]  mux_q, ctl_q;
   logic              load;
   logic [STEP_W-1:0] step;
   step_attr_t        attr;
   logic              no_end;
   stp_state_e        fsm_state;

   seq_cfg_regs #(
      .REG_W     (REG_W),
      .NUM_STEPS (NUM_STEPS),
      .CH_W      (CH_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .mux_wr_en   (mux_wr_en),
      .mux_wr_data (mux_wr_data),
      .ctl_wr_en   (ctl_wr_en),
      .ctl_wr_data (ctl_wr_data),
      .mux_q       (mux_q),
      .ctl_q       (ctl_q)
   );

   seq_step_sel #(
      .REG_W     (REG_W),
      .NUM_STEPS (NUM_STEPS),
      .CH_W      (CH_W),
      .SNAPSHOT  (SNAPSHOT)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .mux_live (mux_q),
      .ctl_live (ctl_q),
      .step     (step),
      .chan     (conv_chan),
      .attr     (attr),
      .no_end   (no_end)
   );

   seq_fsm #(
      .NUM_STEPS (NUM_STEPS),
      .RES_W     (RES_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .conv_done (conv_done),
      .conv_data (conv_data),
      .attr      (attr),
      .no_end    (no_end),
      .load      (load),
      .step      (step),
      .state     (fsm_state),
      .conv_req  (conv_req),
      .res_push  (res_push),
      .res_data  (res_data),
      .irq       (irq),
      .cfg_err   (cfg_err),
      .busy      (busy)
   );

   assign mux_rd_data = mux_q;
   assign ctl_rd_data = ctl_q;
   assign conv_diff   = attr.diff;
   assign conv_temp   = attr.temp;
   assign res_step    = step;

endmodule

// File: rtl/seq_stepper_chk.sv
module seq_stepper_chk
   import seq_stepper_pkg::*;
#(
   parameter int unsigned REG_W     = 16,
   parameter int unsigned NUM_STEPS = 4,
   parameter int unsigned CH_W      = 2,
   parameter int unsigned STEP_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input stp_state_e        fsm_state,
   input logic [REG_W-1:0]  mux_rd_data,
   input logic              conv_req,
   input logic [CH_W-1:0]   conv_chan,
   input logic              conv_diff,
   input logic              conv_temp,
   input logic              conv_done,
   input logic              res_push,
   input logic [STEP_W-1:0] res_step,
   input logic              irq,
   input logic              cfg_err,
   input logic              busy
);

   localparam logic [31:0]      M32   = chan_mask(NUM_STEPS, CH_W);
   localparam logic [REG_W-1:0] RSVD  = ~M32[REG_W-1:0];

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_rd_data & RSVD) == '0);

   p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

   p_sel_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_WAIT_DONE) |->
         ($stable(conv_chan) && $stable(conv_diff) && $stable(conv_temp)));

   p_push_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_push |-> $past(conv_done));

   p_err_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (res_push && res_step == STEP_W'(NUM_STEPS - 1)));

   p_irq_with_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> res_push);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!conv_req && !res_push && !irq));

endmodule

bind seq_stepper seq_stepper_chk #(
   .REG_W     (REG_W),
   .NUM_STEPS (NUM_STEPS),
   .CH_W      (CH_W),
   .STEP_W    (STEP_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fsm_state   (fsm_state),
   .mux_rd_data (mux_rd_data),
   .conv_req    (conv_req),
   .conv_chan   (conv_chan),
   .conv_diff   (conv_diff),
   .conv_temp   (conv_temp),
   .conv_done   (conv_done),
   .res_push    (res_push),
   .res_step    (res_step),
   .irq         (irq),
   .cfg_err     (cfg_err),
   .busy        (busy)
);

// File: tb/seq_stepper_bench.sv
module seq_stepper_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mux_wr_en = 1'b0, ctl_wr_en = 1'b0;
   logic [15:0] mux_wr_data = '0, ctl_wr_data = '0;
   logic [15:0] mux_rd_data, ctl_rd_data;
   logic        trig = 1'b0;
   logic        conv_req, conv_diff, conv_temp;
   logic [1:0]  conv_chan;
   logic        conv_done = 1'b0;
   logic [9:0]  conv_data = '0;
   logic        res_push, irq, cfg_err, busy;
   logic [9:0]  res_data;
   logic [1:0]  res_step;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   seq_stepper u_seq_stepper (
      .clk(clk), .rst_n(rst_n),
      .mux_wr_en(mux_wr_en), .mux_wr_data(mux_wr_data),
      .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
      .mux_rd_data(mux_rd_data), .ctl_rd_data(ctl_rd_data),
      .trig(trig), .conv_req(conv_req), .conv_chan(conv_chan),
      .conv_diff(conv_diff), .conv_temp(conv_temp),
      .conv_done(conv_done), .conv_data(conv_data),
      .res_push(res_push), .res_data(res_data), .res_step(res_step),
      .irq(irq), .cfg_err(cfg_err), .busy(busy)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_noend(input logic [15:0] c);
      return !(c[1] | c[5] | c[9] | c[13]);
   endfunction

   function automatic bit exp_last(input logic [15:0] c, input int s);
      return c[4*s+1] || (s == 3);
   endfunction

   task automatic wr_cfg(input logic [15:0] m, input logic [15:0] c);
      @(negedge clk);
      mux_wr_en = 1'b1; mux_wr_data = m;
      ctl_wr_en = 1'b1; ctl_wr_data = c;
      @(negedge clk);
      mux_wr_en = 1'b0; ctl_wr_en = 1'b0;
   endtask

   task automatic run_seq(input logic [15:0] ma, input logic [15:0] ca,
                          input bit retrig, input bit midw,
                          input logic [15:0] mb, input logic [15:0] cb,
                          input bit spur);
      int nseq = retrig ? 2 : 1;
      int sq = 0;
      int s = 0;
      int cnt = 0;
      int guard = 0;
      bit expect_req = 1'b0;
      bit finished = 1'b0;
      logic [9:0]  sent = '0;
      logic [15:0] m = ma;
      logic [15:0] c = ca;
      wr_cfg(ma, ca);
      @(negedge clk);
      trig = 1'b1;
      while (!finished && guard < 400) begin
         @(negedge clk);
         guard++;
         trig = 1'b0; conv_done = 1'b0; mux_wr_en = 1'b0; ctl_wr_en = 1'b0;
         if (expect_req) begin
            chk("R9", "restart request", int'(conv_req), 1);
            expect_req = 1'b0;
         end
         if (conv_req) begin
            chk("R4", "chan", int'(conv_chan), int'(m[4*s +: 2]));
            chk("R4", "diff", int'(conv_diff), int'(c[4*s]));
            chk("R4", "temp", int'(conv_temp), int'(c[4*s+3]));
            if (sq == 0 && s == 0) begin
               if (retrig) trig = 1'b1;
               if (midw) begin
                  mux_wr_en = 1'b1; mux_wr_data = mb;
                  ctl_wr_en = 1'b1; ctl_wr_data = cb;
               end
            end
            if (spur) begin
               conv_done = 1'b1;
               conv_data = 10'($urandom);
            end
            cnt = 1 + int'($urandom % 4);
         end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               sent = 10'($urandom);
               conv_done = 1'b1;
               conv_data = sent;
            end
         end
         if (res_push) begin
            chk("R5", "data", int'(res_data), int'(sent));
            chk("R5", "step", int'(res_step), s);
            chk("R8", "irq", int'(irq), int'(c[4*s+2]));
            chk("R7", "cfg_err", int'(cfg_err), int'(s == 3 && exp_noend(c)));
            if (exp_last(c, s)) begin
               sq++;
               s = 0;
               if (sq < nseq) begin
                  expect_req = 1'b1;
                  if (midw) begin m = mb; c = cb; end
               end else begin
                  finished = 1'b1;
               end
            end else begin
               s++;
            end
         end
      end
      chk("R6", "sequence completed", int'(finished), 1);
      @(negedge clk);
      chk("R6", "busy after end", int'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EC0_0417));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "mux rd", int'(mux_rd_data), 0);
      chk("R1", "ctl rd", int'(ctl_rd_data), 0);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "req/push/irq/err", int'({conv_req, res_push, irq, cfg_err}), 0);

      // R2 / R3 register layout
      wr_cfg(16'hFFFF, 16'hA5C3);
      chk("R2", "mux all ones", int'(mux_rd_data), 16'h3333);
      chk("R3", "ctl readback", int'(ctl_rd_data), 16'hA5C3);
      wr_cfg(16'h5A5A, 16'h1234);
      chk("R2", "mux pattern", int'(mux_rd_data), 16'h1212);
      chk("R3", "ctl pattern", int'(ctl_rd_data), 16'h1234);

      // R11 done while idle is ignored
      @(negedge clk);
      conv_done = 1'b1; conv_data = 10'h155;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         conv_done = 1'b0;
         chk("R11", "idle done push", int'(res_push), 0);
         chk("R11", "idle done busy", int'(busy), 0);
      end

      // directed: end on step 0, step 2, step 3 only, none, all irq
      run_seq(16'h0003, 16'h000B, 0, 0, 0, 0, 0);
      run_seq(16'h2103, 16'h0745, 0, 0, 0, 0, 0);
      run_seq(16'h3210, 16'h2D9C, 0, 0, 0, 0, 0);
      run_seq(16'h1302, 16'hDC9D, 0, 0, 0, 0, 0);
      run_seq(16'h0123, 16'h6444, 0, 0, 0, 0, 1);
      // R9 / R10 held trigger and write during run
      run_seq(16'h0001, 16'h0024, 1, 0, 0, 0, 0);
      run_seq(16'h3213, 16'h0200, 1, 1, 16'h0002, 16'h00CA, 0);
      run_seq(16'h1111, 16'h0020, 0, 1, 16'h3333, 16'hFFFF, 0);

      // constrained random
      for (int k = 0; k < 40; k++) begin
         logic [15:0] ra, rb, rc, rd;
         ra = 16'($urandom); rc = 16'($urandom);
         rb = 16'($urandom); rd = 16'($urandom);
         if (($urandom % 4) == 0) rc = rc & 16'hDDDD;
         run_seq(ra, rc, bit'($urandom % 2), bit'($urandom % 2), rb, rd,
                 bit'($urandom % 2));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule